// File: doc/BRIEF.md
# DisplayPort AUX Request Framer

This block sits between a requester and an AUX channel engine. It takes one AUX transaction request (a 4-bit command, a 20-bit address, a payload length and up to twelve bytes of write data) and turns it into the header-plus-payload byte stream that the channel engine transmits. The stream leaves on a valid/ready byte interface. A one-cycle start pulse and the total transmit length go with it.

When the channel engine reports back, the framer decodes the reply. The engine supplies an acknowledge/status byte and the number of bytes it received. The framer returns either an error code or a byte count, together with the sink's reply code. Requests that are too long or have an unknown command are refused at once, and nothing is transmitted for them. Only one request is handled at a time.

Top module: `dp_aux_framer`

## Requirements
- R1: Header byte 0 is address[7:0] and byte 1 is address[15:8]. Byte 2 carries the command in bits [7:4] and address[19:16] in bits [3:0]. Bytes are sent in the order 0, 1, 2, 3, then payload bytes starting with write-data byte 0 (req_wdata[7:0]).
- R2: Bits [3:0] of header byte 3 hold the payload length minus one, or 0 when the length is 0.
- R3: Bits [7:4] of header byte 3 depend on the request. They are 3 for any zero-length request and 4 for a read with a nonzero length. For a write with a nonzero length they are the low four bits of (4 + length), so a 12-byte write gives 0.
- R4: tx_len is 4 + length for a write and 4 for any read. A zero-length write also has tx_len 4, so byte 3 is always sent.
- R5: A request with a length above 16 is refused with done_code 1 (too big), whatever its command. A write-type request with a length above 12 is also refused with code 1. Neither kind produces a start pulse.
- R6: The command is classified with bit 2 (the I2C middle-of-transaction flag) cleared. Writes are 0 (I2C write), 2 (I2C write-status-update) and 8 (native write). Reads are 1 (I2C read) and 9 (native read). Any other code with length ≤ 16 is refused with done_code 2 (bad command) and is not transmitted.
- R7: An acknowledge byte equal to 1, 2 or 3 ends the transaction with done_err set. The done_code is 3 for 1 (timeout), 4 for 2 (flags nonzero) and 5 for 3 (link error). done_count and done_reply are 0 in this case.
- R8: A successful read reports done_count = min(rx_count, request length) and done_reply = ack[7:4], with done_code 0.
- R9: A successful write reports done_count equal to the payload length, not the transmitted byte count, and done_reply = ack[7:4].
- R10: req_ready falls in the cycle the start pulse is high. It stays low until the cycle in which done reports the reply. Requests presented while it is low are ignored.
- R11: tx_start is a single-cycle pulse. While tx_valid is high and tx_ready is low, tx_data holds its value. tx_valid falls after the last of the tx_len bytes has been accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Framer idle, request accepted when valid |
| req_cmd | input | 4 | AUX command code |
| req_addr | input | 20 | Transaction address |
| req_len | input | 5 | Payload length in bytes |
| req_wdata | input | 96 | Write payload, byte 0 in bits [7:0] |
| tx_start | output | 1 | One-cycle pulse when a transmission begins |
| tx_len | output | 5 | Total bytes to transmit |
| tx_valid | output | 1 | tx_data holds a byte |
| tx_ready | input | 1 | Channel engine takes the byte |
| tx_data | output | 8 | Transmit byte |
| rx_valid | input | 1 | Reply present |
| rx_ack | input | 8 | Acknowledge/status byte from the engine |
| rx_count | input | 5 | Bytes received by the engine |
| done | output | 1 | One-cycle result pulse |
| done_err | output | 1 | Result is an error |
| done_code | output | 3 | 0 ok, 1 too big, 2 bad command, 3 timeout, 4 flags, 5 link error |
| done_count | output | 5 | Byte count on success |
| done_reply | output | 4 | Sink reply code on success |

## Verification
A refused request shows its done pulse one cycle after the edge that accepts it. An accepted request shows tx_start, tx_len and the first tx_data byte in that same cycle. Each stream byte is checked every cycle it is valid, and the handshake is counted at the following edge. A reply presented at an edge shows done one cycle later, and done falls again one cycle after that. The bench drives all inputs on the falling edge and samples outputs there, half a cycle after the edge that produced them, so each check lines up with the single register between stimulus and result.

// File: rtl/dp_aux_framer.sv
module dp_aux_framer #(
  parameter int MAX_WR = 12,
  parameter int MAX_RD = 16,
  parameter int LW     = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [3:0]        req_cmd,
  input  logic [19:0]       req_addr,
  input  logic [LW-1:0]     req_len,
  input  logic [MAX_WR*8-1:0] req_wdata,
  output logic              tx_start,
  output logic [LW-1:0]     tx_len,
  output logic              tx_valid,
  input  logic              tx_ready,
  output logic [7:0]        tx_data,
  input  logic              rx_valid,
  input  logic [7:0]        rx_ack,
  input  logic [LW-1:0]     rx_count,
  output logic              done,
  output logic              done_err,
  output logic [2:0]        done_code,
  output logic [LW-1:0]     done_count,
  output logic [3:0]        done_reply
);
  localparam int HDR = 4;
  localparam int WDW = MAX_WR * 8;
  localparam logic [2:0] C_OK = 3'd0, C_BIG = 3'd1, C_CMD = 3'd2,
                         C_TMO = 3'd3, C_FLG = 3'd4, C_LNK = 3'd5;

  typedef enum logic [1:0] {S_IDLE, S_SEND, S_WAIT} state_t;
  state_t st;

  logic [3:0]    cmd_q;
  logic [19:0]   addr_q;
  logic [LW-1:0] len_q, idx_q;
  logic [WDW-1:0] wdata_q;
  logic          wr_q;

  wire [3:0] base = req_cmd & 4'b1011;
  wire is_wr  = (base == 4'd0) || (base == 4'd2) || (base == 4'd8);
  wire is_rd  = (base == 4'd1) || (base == 4'd9);
  wire big    = (req_len > LW'(MAX_RD)) || (is_wr && req_len > LW'(MAX_WR));
  wire reject = big || !(is_wr || is_rd);

  wire [LW-1:0] tot = LW'(HDR) + len_q;
  wire [3:0] b3_hi  = (len_q == '0) ? 4'd3 : (wr_q ? tot[3:0] : 4'd4);
  wire [3:0] b3_lo  = (len_q == '0) ? 4'd0 : 4'(len_q - LW'(1));
  wire [LW-1:0] pidx = idx_q - LW'(HDR);

  assign req_ready = (st == S_IDLE);
  assign tx_valid  = (st == S_SEND);
  assign tx_len    = wr_q ? tot : LW'(HDR);

  always_comb begin
    case (idx_q)
      LW'(0):  tx_data = addr_q[7:0];
      LW'(1):  tx_data = addr_q[15:8];
      LW'(2):  tx_data = {cmd_q, addr_q[19:16]};
      LW'(3):  tx_data = {b3_hi, b3_lo};
      default: tx_data = 8'(wdata_q >> {pidx, 3'b000});
    endcase
  end

  wire st_err = (rx_ack == 8'd1) || (rx_ack == 8'd2) || (rx_ack == 8'd3);
  wire [LW-1:0] rd_cnt = (rx_count > len_q) ? len_q : rx_count;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE; tx_start <= 1'b0; done <= 1'b0; done_err <= 1'b0;
      done_code <= C_OK; done_count <= '0; done_reply <= '0;
      cmd_q <= '0; addr_q <= '0; len_q <= '0; wdata_q <= '0; wr_q <= 1'b0; idx_q <= '0;
    end else begin
      tx_start <= 1'b0;
      done     <= 1'b0;
      case (st)
        S_IDLE: if (req_valid) begin
          if (reject) begin
            done <= 1'b1; done_err <= 1'b1; done_code <= big ? C_BIG : C_CMD;
            done_count <= '0; done_reply <= '0;
          end else begin
            cmd_q <= req_cmd; addr_q <= req_addr; len_q <= req_len;
            wdata_q <= req_wdata; wr_q <= is_wr; idx_q <= '0;
            tx_start <= 1'b1; st <= S_SEND;
          end
        end
        S_SEND: if (tx_ready) begin
          if (idx_q == tx_len - LW'(1)) st <= S_WAIT;
          else idx_q <= idx_q + LW'(1);
        end
        S_WAIT: if (rx_valid) begin
          done <= 1'b1; st <= S_IDLE;
          if (st_err) begin
            done_err <= 1'b1; done_count <= '0; done_reply <= '0;
            done_code <= (rx_ack == 8'd1) ? C_TMO : (rx_ack == 8'd2) ? C_FLG : C_LNK;
          end else begin
            done_err <= 1'b0; done_code <= C_OK;
            done_count <= wr_q ? len_q : rd_cnt;
            done_reply <= rx_ack[7:4];
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assert_start_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    tx_start |=> !tx_start);
  assert_start_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
    tx_start |-> (!req_ready && tx_valid));
  assert_hold_data_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data)));
  assert_err_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (done && done_err) |-> (done_count == '0 && done_reply == '0));
  assert_count_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !done_err) |-> (done_count <= LW'(MAX_RD)));
  assert_txlen_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> (tx_len >= LW'(HDR) && tx_len <= LW'(HDR + MAX_WR)));
  assert_done_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> req_ready);
endmodule

// File: tb/dp_aux_framer_bench.sv
module dp_aux_framer_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  always #2 clk = ~clk;

  logic req_valid = 0, tx_ready = 0, rx_valid = 0;
  logic [3:0] req_cmd = 0; logic [19:0] req_addr = 0; logic [4:0] req_len = 0;
  logic [95:0] req_wdata = 0; logic [7:0] rx_ack = 0; logic [4:0] rx_count = 0;
  logic req_ready, tx_start, tx_valid, done, done_err;
  logic [4:0] tx_len, done_count; logic [7:0] tx_data; logic [2:0] done_code; logic [3:0] done_reply;

  dp_aux_framer u_dp_aux_framer (.*);

  int checks = 0, fails = 0; bit finished = 0;

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin fails++; $display("FAIL %s actual=%0h expected=%0h", tag, act, exp); end
  endtask

  function automatic bit is_w(logic [3:0] c);
    logic [3:0] b = c & 4'hB; return b == 0 || b == 2 || b == 8;
  endfunction
  function automatic bit is_r(logic [3:0] c);
    logic [3:0] b = c & 4'hB; return b == 1 || b == 9;
  endfunction
  function automatic int rej_code(logic [3:0] c, int len);
    if (len > 16) return 1;
    if (!is_w(c) && !is_r(c)) return 2;
    if (is_w(c) && len > 12) return 1;
    return 0;
  endfunction
  function automatic logic [7:0] exp_byte(logic [3:0] c, logic [19:0] a, int len, logic [95:0] wd, int i);
    logic [3:0] hi, lo;
    case (i)
      0: return a[7:0];
      1: return a[15:8];
      2: return {c, a[19:16]};
      3: begin
        lo = (len == 0) ? 4'd0 : 4'(len - 1);
        hi = (len == 0) ? 4'd3 : (is_w(c) ? 4'(4 + len) : 4'd4);
        return {hi, lo};
      end
      default: return wd[(i-4)*8 +: 8];
    endcase
  endfunction

  task automatic run(logic [3:0] c, logic [19:0] a, int len, logic [95:0] wd,
                     logic [7:0] ack, int rc, bit intrude);
    int rj = rej_code(c, len);
    int tl = is_w(c) ? 4 + len : 4;
    int idx = 0, guard = 0;
    @(negedge clk);
    req_cmd = c; req_addr = a; req_len = 5'(len); req_wdata = wd; req_valid = 1;
    @(posedge clk); @(negedge clk); req_valid = 0;
    if (rj != 0) begin
      chk(done && done_err, "R5/R6 refuse done", {done, done_err}, 3);
      chk(done_code == 3'(rj), rj == 1 ? "R5 code" : "R6 code", done_code, rj);
      chk(!tx_start, "R5 no start", tx_start, 0);
      @(negedge clk);
      chk(!done && !tx_valid, "R6 no stream", {done, tx_valid}, 0);
      return;
    end
    chk(tx_start && !req_ready, "R10 start/busy", {tx_start, req_ready}, 2);
    chk(tx_len == 5'(tl), "R4 tx_len", tx_len, tl);
    while (idx < tl && guard < 200) begin
      tx_ready = ($urandom % 3) != 0;
      chk(tx_valid, "R11 valid", tx_valid, 1);
      chk(tx_data == exp_byte(c, a, len, wd, idx), idx < 3 ? "R1 hdr" : idx == 3 ? "R2/R3 byte3" : "R1 payload",
          tx_data, exp_byte(c, a, len, wd, idx));
      @(posedge clk);
      if (tx_ready) idx++;
      @(negedge clk); guard++;
      if (idx == 1 && guard == 1) chk(!tx_start, "R11 pulse", tx_start, 0);
    end
    tx_ready = 0;
    chk(!tx_valid, "R11 end", tx_valid, 0);
    if (intrude) begin
      req_cmd = 4'h9; req_len = 1; req_valid = 1;
      repeat (2) @(negedge clk);
      chk(!req_ready && !tx_start, "R10 busy ignore", {req_ready, tx_start}, 0);
    end
    rx_valid = 1; rx_ack = ack; rx_count = 5'(rc);
    @(posedge clk); @(negedge clk); rx_valid = 0; req_valid = 0;
    chk(done && req_ready, "R10 done", {done, req_ready}, 3);
    if (ack >= 1 && ack <= 3) begin
      chk(done_err && done_code == 3'(ack + 2), "R7 status", done_code, ack + 2);
      chk(done_count == 0 && done_reply == 0, "R7 clear", {done_count, done_reply}, 0);
    end else begin
      int ec = is_w(c) ? len : (rc > len ? len : rc);
      chk(!done_err && done_code == 0, "R8/R9 ok", done_code, 0);
      chk(done_count == 5'(ec), is_w(c) ? "R9 count" : "R8 count", done_count, ec);
      chk(done_reply == ack[7:4], "R8 reply", done_reply, ack[7:4]);
    end
    @(negedge clk);
    chk(!done && !tx_start, "R10 one result", {done, tx_start}, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      fails++; checks++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(req_ready && !done && !tx_valid && !tx_start, "reset state R10", {req_ready, done, tx_valid, tx_start}, 8);
    run(4'h9, 20'hABCDE, 0, 0, 8'h00, 3, 0);                 // R3 bare read: byte3 0x30
    run(4'h8, 20'h12345, 0, 0, 8'h00, 0, 0);                 // R4 bare write: 4 bytes
    run(4'h8, 20'h00F0F, 12, 96'h0C0B0A090807060504030201, 8'h00, 0, 0); // R3 hi nibble 0
    run(4'h0, 20'h00050, 13, 0, 8'h00, 0, 0);                // R5 write over 12
    run(4'h9, 20'h00100, 16, 0, 8'h10, 20, 0);               // R8 clamp at 16
    run(4'h1, 20'h00100, 17, 0, 8'h00, 0, 0);                // R5 read over 16
    run(4'hA, 20'h00000, 2, 0, 8'h00, 0, 0);                 // R6 bad cmd
    run(4'h3, 20'h00000, 14, 0, 8'h00, 0, 0);                // R6 bad cmd not size
    run(4'h5, 20'h00050, 5, 0, 8'h20, 2, 0);                 // R6 MOT read, R8 short
    run(4'h6, 20'h00050, 3, 96'hAA5533, 8'h00, 0, 0);        // R6 MOT status-update write
    run(4'h9, 20'h00200, 5, 0, 8'h01, 5, 0);                 // R7 timeout
    run(4'h8, 20'h00200, 4, 96'h11223344, 8'h02, 0, 0);      // R7 flags
    run(4'h1, 20'h00200, 4, 0, 8'h03, 4, 1);                 // R7 link err, R10 intrude
    for (int n = 0; n < 300; n++) begin
      logic [7:0] ak;
      int sel = $urandom % 8;
      ak = (sel < 3) ? 8'(sel + 1) : 8'($urandom % 16) << 4;
      run(4'($urandom), 20'($urandom), int'($urandom % 19), {$urandom, $urandom, $urandom},
          ak, int'($urandom % 24), ($urandom % 10) == 0);
    end
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule